// File: doc/BRIEF.md
# Per-Target Priority Threshold Selector

This block serves one interrupt target. Every cycle it looks at all interrupt sources that are both pending and enabled for the target. It picks the one with the largest priority value, and on a tie it picks the lowest source index. It reports that source's ID and priority. Separately, it raises a request line when the winning priority is strictly above the target's threshold.

The reported ID is what a claim would return. It ignores the threshold, so a low-priority source can still be claimed while the request line stays quiet. Index 0 is reserved to mean "nothing", so source bit 0 never takes part in selection.

All three results are registered and follow the inputs by one clock. One instance is placed per target. The instances share the pending and priority vectors, and each has its own enable vector and threshold.

Top module: `prio_threshold_sel`

## Requirements
- R1: Source bit 0 never wins, whatever its pending, enable and priority inputs are; an ID of 0 on `claim_id_o` means no source was selected.
- R2: A source at index k ≥ 1 is a candidate only when `pend_i[k]` and `en_i[k]` are both 1. Pending-but-disabled and enabled-but-idle sources have no effect on the outputs.
- R3: Among candidates, the source with the largest priority value (`prio_i[k*PW +: PW]`) is selected, and its priority appears on `claim_prio_o`.
- R4: When several candidates share the largest priority, the one with the lowest index is selected.
- R5: The selected ID and priority are reported even when that priority is not above `thr_i`.
- R6: `irq_o` is 1 exactly when a candidate exists and its priority is strictly greater than `thr_i`. An equal priority, or a priority of 0, does not raise it.
- R7: With `thr_i` equal to MAX_PRIO, `irq_o` stays 0 for every input pattern.
- R8: With no candidate, `claim_id_o` and `claim_prio_o` are 0 and `irq_o` is 0.
- R9: All outputs are registered and show the result for the inputs present at the previous rising clock edge. While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_SOURCE | Pending bit per source |
| en_i | input | N_SOURCE | Enable bit per source for this target |
| prio_i | input | N_SOURCE*PW | Priority per source, source k in bits [k*PW +: PW] |
| thr_i | input | PW | Target threshold |
| claim_id_o | output | IW | Index of the selected source, 0 if none |
| claim_prio_o | output | PW | Priority of the selected source, 0 if none |
| irq_o | output | 1 | Notification request to the target |

## Verification
Every output of this block is due at the first rising edge after a new input pattern is applied. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, which is half a cycle after the edge that captured the result. One directed case also samples before that edge, to confirm that the outputs still hold the previous result. The remaining patterns are an exhaustive sweep of pending masks and thresholds, plus random patterns, each compared against a loop model built from the requirements.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    // Bit width needed to index n values, at least one bit.
    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/irq_cand_mask.sv
module irq_cand_mask #(
    parameter int unsigned N_SOURCE = 32
) (
    input  logic [N_SOURCE-1:0] pend_i,
    input  logic [N_SOURCE-1:0] en_i,
    output logic [N_SOURCE-1:0] cand_o
);
    // Index 0 stands for "no interrupt"; its inputs are deliberately dropped.
    logic unused_src0;
    assign unused_src0 = pend_i[0] ^ en_i[0];

    assign cand_o[0] = 1'b0;
    for (genvar k = 1; k < N_SOURCE; k++) begin : g_src
        assign cand_o[k] = pend_i[k] & en_i[k];
    end
endmodule

// File: rtl/irq_max_tree.sv
module irq_max_tree
    import irq_sel_pkg::*;
#(
    parameter int unsigned N_SOURCE = 32,
    parameter int unsigned PW       = 3,
    parameter int unsigned IW       = 5
) (
    input  logic [N_SOURCE-1:0]    cand_i,
    input  logic [N_SOURCE*PW-1:0] prio_i,
    output logic                   win_valid_o,
    output logic [PW-1:0]          win_prio_o,
    output logic [IW-1:0]          win_id_o
);
    localparam int unsigned LEVELS = width_of(N_SOURCE);
    localparam int unsigned LEAVES = 1 << LEVELS;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    // Heap-ordered tournament: node i has children 2i+1 (lower IDs) and 2i+2.
    logic          node_v [NODES];
    logic [PW-1:0] node_p [NODES];
    logic [IW-1:0] node_i [NODES];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < N_SOURCE) begin : g_real
            assign node_v[LEAVES-1+k] = cand_i[k];
            assign node_p[LEAVES-1+k] = prio_i[k*PW +: PW];
            assign node_i[LEAVES-1+k] = IW'(k);
        end else begin : g_pad
            assign node_v[LEAVES-1+k] = 1'b0;
            assign node_p[LEAVES-1+k] = '0;
            assign node_i[LEAVES-1+k] = '0;
        end
    end

    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        logic take_lo;
        // Ties resolve toward the lower-ID subtree.
        assign take_lo   = node_v[2*n+1] &&
                           (!node_v[2*n+2] || (node_p[2*n+1] >= node_p[2*n+2]));
        assign node_v[n] = node_v[2*n+1] | node_v[2*n+2];
        assign node_p[n] = take_lo ? node_p[2*n+1] : node_p[2*n+2];
        assign node_i[n] = take_lo ? node_i[2*n+1] : node_i[2*n+2];
    end

    assign win_valid_o = node_v[0];
    assign win_prio_o  = node_v[0] ? node_p[0] : '0;
    assign win_id_o    = node_v[0] ? node_i[0] : '0;
endmodule

// File: rtl/irq_thresh_gate.sv
module irq_thresh_gate #(
    parameter int unsigned PW = 3
) (
    input  logic          valid_i,
    input  logic [PW-1:0] prio_i,
    input  logic [PW-1:0] thr_i,
    output logic          notify_o
);
    assign notify_o = valid_i && (prio_i > thr_i);
endmodule

// File: rtl/prio_threshold_sel.sv
module prio_threshold_sel
    import irq_sel_pkg::*;
#(
    parameter int unsigned N_SOURCE = 32,
    parameter int unsigned MAX_PRIO = 7,
    parameter int unsigned PW       = width_of(MAX_PRIO + 1),
    parameter int unsigned IW       = width_of(N_SOURCE)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [N_SOURCE-1:0]    pend_i,
    input  logic [N_SOURCE-1:0]    en_i,
    input  logic [N_SOURCE*PW-1:0] prio_i,
    input  logic [PW-1:0]          thr_i,
    output logic [IW-1:0]          claim_id_o,
    output logic [PW-1:0]          claim_prio_o,
    output logic                   irq_o
);
    typedef struct packed {
        logic [IW-1:0] id;
        logic [PW-1:0] prio;
        logic          irq;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [N_SOURCE-1:0] cand;
    logic                win_valid;
    logic [PW-1:0]       win_prio;
    logic [IW-1:0]       win_id;
    logic                notify;

    irq_cand_mask #(.N_SOURCE(N_SOURCE)) u_mask (
        .pend_i (pend_i),
        .en_i   (en_i),
        .cand_o (cand)
    );

    irq_max_tree #(.N_SOURCE(N_SOURCE), .PW(PW), .IW(IW)) u_tree (
        .cand_i      (cand),
        .prio_i      (prio_i),
        .win_valid_o (win_valid),
        .win_prio_o  (win_prio),
        .win_id_o    (win_id)
    );

    irq_thresh_gate #(.PW(PW)) u_gate (
        .valid_i  (win_valid),
        .prio_i   (win_prio),
        .thr_i    (thr_i),
        .notify_o (notify)
    );

    always_comb begin
        st_d      = st_q;
        st_d.id   = win_id;
        st_d.prio = win_prio;
        st_d.irq  = notify;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign claim_id_o   = st_q.id;
    assign claim_prio_o = st_q.prio;
    assign irq_o        = st_q.irq;
endmodule

// File: rtl/prio_threshold_sel_chk.sv
module prio_threshold_sel_chk #(
    parameter int unsigned N_SOURCE = 32,
    parameter int unsigned MAX_PRIO = 7,
    parameter int unsigned PW       = 3,
    parameter int unsigned IW       = 5
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [N_SOURCE-1:0]    pend_i,
    input logic [N_SOURCE-1:0]    en_i,
    input logic [N_SOURCE*PW-1:0] prio_i,
    input logic [PW-1:0]          thr_i,
    input logic [IW-1:0]          claim_id_o,
    input logic [PW-1:0]          claim_prio_o,
    input logic                   irq_o
);
    logic [N_SOURCE-1:0] live;
    assign live = pend_i & en_i;

    assert_src0_never_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (claim_id_o != '0));

    assert_winner_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_id_o != '0) |-> ((($past(live) >> claim_id_o) & 1) != 0));

    assert_strict_above_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (claim_prio_o > $past(thr_i)));

    assert_zero_prio_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_prio_o == '0) |-> !irq_o);

    assert_max_thr_mutes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(thr_i) == PW'(MAX_PRIO)) |-> !irq_o);

    assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(live[N_SOURCE-1:1]) == '0) |-> (claim_id_o == '0 && claim_prio_o == '0 && !irq_o));
endmodule

bind prio_threshold_sel prio_threshold_sel_chk #(
    .N_SOURCE(N_SOURCE), .MAX_PRIO(MAX_PRIO), .PW(PW), .IW(IW)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_i       (pend_i),
    .en_i         (en_i),
    .prio_i       (prio_i),
    .thr_i        (thr_i),
    .claim_id_o   (claim_id_o),
    .claim_prio_o (claim_prio_o),
    .irq_o        (irq_o)
);

// File: tb/sim_prio_threshold_sel.sv
module sim_prio_threshold_sel;
    localparam int N  = 8;
    localparam int MP = 3;
    localparam int PW = 2;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      pend = '0;
    logic [N-1:0]      en = '0;
    logic [N*PW-1:0]   prio = '0;
    logic [PW-1:0]     thr = '0;
    logic [IW-1:0]     id_o;
    logic [PW-1:0]     prio_o;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    prio_threshold_sel #(.N_SOURCE(N), .MAX_PRIO(MP)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
        .thr_i(thr), .claim_id_o(id_o), .claim_prio_o(prio_o), .irq_o(irq)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Loop model: strict > keeps the lowest index on ties.
    task automatic model(input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [N*PW-1:0] pr, input logic [PW-1:0] t,
                         output int xid, output int xprio, output int xirq);
        bit found = 0;
        xid = 0; xprio = 0;
        for (int k = 1; k < N; k++) begin
            if (p[k] && e[k]) begin
                int pk = int'(pr[k*PW +: PW]);
                if (!found || pk > xprio) begin
                    found = 1; xid = k; xprio = pk;
                end
            end
        end
        xirq = (found && xprio > int'(t)) ? 1 : 0;
    endtask

    task automatic apply(input string tag, input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [N*PW-1:0] pr, input logic [PW-1:0] t);
        int xid, xprio, xirq;
        @(negedge clk);
        pend = p; en = e; prio = pr; thr = t;
        @(posedge clk);
        @(negedge clk);
        model(p, e, pr, t, xid, xprio, xirq);
        check(tag, "id", int'(id_o), xid);
        check(tag, "prio", int'(prio_o), xprio);
        check(tag, "irq", int'(irq), xirq);
    endtask

    function automatic logic [N*PW-1:0] pv(input int p7, p6, p5, p4, p3, p2, p1, p0);
        return {PW'(p7), PW'(p6), PW'(p5), PW'(p4), PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        pend = '1; en = '1; prio = '1; thr = '0;
        repeat (3) @(negedge clk);
        check("R9", "reset id", int'(id_o), 0);
        check("R9", "reset prio", int'(prio_o), 0);
        check("R9", "reset irq", int'(irq), 0);
        rst_n = 1'b1;

        // R1: only source 0 active
        apply("R1", 8'h01, 8'h01, pv(0,0,0,0,0,0,0,3), 2'd0);
        // R2: disabled source 5 high, enabled source 2 low
        apply("R2", 8'h24, 8'h04, pv(0,0,3,0,0,1,0,0), 2'd0);
        // R2: enabled but idle source 6
        apply("R2", 8'h08, 8'h48, pv(0,3,0,0,2,0,0,0), 2'd0);
        // R3: highest priority wins
        apply("R3", 8'hFE, 8'hFE, pv(1,2,0,3,1,2,1,0), 2'd0);
        // R4: tie between 3 and 6
        apply("R4", 8'h48, 8'hFF, pv(0,2,0,0,2,0,0,0), 2'd0);
        // R4: all equal, lowest index 1
        apply("R4", 8'hFE, 8'hFE, pv(2,2,2,2,2,2,2,2), 2'd1);
        // R5: winner below threshold is still reported
        apply("R5", 8'h10, 8'h10, pv(0,0,0,1,0,0,0,0), 2'd2);
        // R6: equal to threshold -> no irq; above -> irq; zero prio -> no irq
        apply("R6", 8'h02, 8'h02, pv(0,0,0,0,0,0,2,0), 2'd2);
        apply("R6", 8'h02, 8'h02, pv(0,0,0,0,0,0,3,0), 2'd2);
        apply("R6", 8'h80, 8'h80, pv(0,0,0,0,0,0,0,0), 2'd0);
        // R7: max threshold mutes
        apply("R7", 8'hFE, 8'hFE, pv(3,3,3,3,3,3,3,3), 2'd3);
        // R8: nothing live
        apply("R8", 8'hF0, 8'h0F, pv(3,3,3,3,3,3,3,3), 2'd0);

        // R9: output holds until the next rising edge
        @(negedge clk);
        pend = 8'h04; en = 8'h04; prio = pv(0,0,0,0,0,3,0,0); thr = 2'd0;
        #1;
        check("R9", "held id", int'(id_o), 0);
        check("R9", "held irq", int'(irq), 0);
        @(posedge clk);
        @(negedge clk);
        check("R9", "next id", int'(id_o), 2);
        check("R9", "next irq", int'(irq), 1);

        // R3: exhaustive sweep of pending masks and thresholds
        for (int m = 0; m < 256; m++) begin
            for (int t = 0; t <= MP; t++) begin
                apply("R3", 8'(m), 8'hFF, pv(1,3,2,0,3,1,2,3), 2'(t));
            end
        end

        // R2/R4/R6: random patterns
        for (int r = 0; r < 2500; r++) begin
            apply("R6", 8'($urandom), 8'($urandom), 16'($urandom), 2'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule